// File: doc/BRIEF.md
# Temperature Compensation Sense Scheduler

This block decides when a temperature sense-and-correct cycle runs and which gain code that cycle applies. A host programs one control register through a simple write port. The register holds a sense-enable flag, two battery-mode flags (enable and rate) and a 4-bit gain code. The block counts 1 Hz ticks and raises a one-clock `sense_req` pulse when the selected interval has elapsed. On that same pulse it latches the committed gain code onto `gain_q`, where the correction arithmetic reads it.

A new gain code takes effect only through a two-write handshake:

1. The code is written with sense-enable cleared.
2. The identical code is written again with sense-enable set.

Codes outside the legal window are dropped. The block also keeps the final analog and digital trim results that the correction engine loads. The host reads them through a registered read port and cannot write them. A flag marks the all-ones digital trim code, which stands for a negative adjustment.

Top module: `tsense_sched`

## Requirements
- R1: After reset the control flags are 0, the committed gain is 1000, `gain_q` is 1000, `sense_req` is 0, and both trim results are 0.
- R2: On main supply (`on_battery`=0) with sense-enable set, `sense_req` fires once every 60 ticks.
- R3: On battery, the battery-enable and rate flags select the interval: 0x gives no pulses, 10 gives one pulse every 600 ticks, and 11 gives one pulse every 60 ticks.
- R4: With sense-enable cleared, `sense_req` never fires, whatever the supply state or battery flags.
- R5: `sense_req` is high for exactly one clock per firing.
- R6: The tick count restarts from zero whenever the selected interval class (off, 60, 600) changes, and it stays at zero while that class is off.
- R7: A write to address 0 with bit 7 (sense-enable) clear stages its gain field (bits 3:0). A later write to address 0 with bit 7 set and the same gain field commits it. An enabling write with a different code commits nothing and leaves the staged code in place.
- R8: A gain field below 0100 or above 1100 is neither staged nor committed, and the committed code is kept.
- R9: `gain_q` changes only in the cycle `sense_req` is high. It then carries the committed gain that was in force at the firing tick.
- R10: The read data appears one clock after `rd_addr` is set, with this map:
  - address 0 gives {enable, battery-enable, rate, 0, gain};
  - address 1 gives the 6-bit analog trim in bits 5:0;
  - address 2 gives the 3-bit digital trim in bits 2:0;
  - address 3 gives 0.

  Host writes to addresses 1 to 3 change nothing.
- R11: `trim_dig_neg` is 1 exactly when the loaded digital trim code is 111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 2 | Host write address |
| wr_data | input | 8 | Host write data (bit 7 sense-enable, bit 6 battery-enable, bit 5 rate, bits 3:0 gain) |
| rd_addr | input | 2 | Host read address |
| rd_data | output | 8 | Registered host read data |
| on_battery | input | 1 | 1 when running from the backup supply |
| tick_1hz | input | 1 | One-clock tick once per second |
| trim_ld | input | 1 | Correction engine load strobe for the trim results |
| trim_ana | input | 6 | Final analog trim from the correction engine |
| trim_dig | input | 3 | Final digital trim from the correction engine |
| sense_req | output | 1 | One-clock request for a sense cycle |
| gain_q | output | 4 | Gain code latched for the current sense cycle |
| trim_dig_neg | output | 1 | Loaded digital trim is the negative code |

## Verification
The hardest situation to reach is a restart in the middle of an interval. The count has to be partly advanced, then the interval class must change (or sensing must turn off and on again), and the bench must then show that the full 59 further ticks pass without a pulse before the 60th tick fires. The bench gets there by running the count to a known offset from the previous pulse, switching battery flags or toggling sense-enable, and counting pulses tick by tick. The gain handshake is driven through mismatched, out-of-window and boundary codes. Each case is followed by a read of address 0 and a wait for the next pulse, which shows which code reached `gain_q`.

// File: rtl/tsense_pkg.sv
package tsense_pkg;

  // Interval class chosen from supply state and control flags
  typedef enum logic [1:0] {
    PER_OFF   = 2'd0,
    PER_SHORT = 2'd1,
    PER_LONG  = 2'd2
  } period_e;

  // Control flags held in the host register at address 0
  typedef struct packed {
    logic sen;
    logic ben;
    logic rate;
  } ctl_t;

  localparam int DATA_W   = 8;
  localparam int SEN_BIT  = 7;
  localparam int BEN_BIT  = 6;
  localparam int RATE_BIT = 5;

  function automatic period_e pick_period(input ctl_t c, input logic batt);
    if (!c.sen)      return PER_OFF;
    else if (!batt)  return PER_SHORT;
    else if (!c.ben) return PER_OFF;
    else if (c.rate) return PER_SHORT;
    else             return PER_LONG;
  endfunction

endpackage

// File: rtl/tsense_ctl_regs.sv
module tsense_ctl_regs
  import tsense_pkg::*;
#(
  parameter int ADDR_W     = 2,
  parameter int GAIN_W     = 4,
  parameter int GAIN_MIN   = 4,
  parameter int GAIN_MAX   = 12,
  parameter int GAIN_RESET = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output ctl_t              ctl,
  output logic [GAIN_W-1:0] gain_comm
);

  localparam logic [GAIN_W-1:0] G_LO  = GAIN_MIN[GAIN_W-1:0];
  localparam logic [GAIN_W-1:0] G_HI  = GAIN_MAX[GAIN_W-1:0];
  localparam logic [GAIN_W-1:0] G_RST = GAIN_RESET[GAIN_W-1:0];
  localparam logic [ADDR_W-1:0] A_CTL = '0;

  logic [GAIN_W-1:0] wr_gain;
  logic [GAIN_W-1:0] pend;
  logic              pend_vld;
  logic              sel;
  logic              legal;
  logic              stage_hit;
  logic              commit_hit;
  logic              unused_data;

  assign wr_gain     = wr_data[GAIN_W-1:0];
  assign unused_data = ^wr_data[RATE_BIT-1:GAIN_W];
  assign sel         = wr_en && (wr_addr == A_CTL);
  assign legal       = (wr_gain >= G_LO) && (wr_gain <= G_HI);
  assign stage_hit   = sel && legal && !wr_data[SEN_BIT];
  assign commit_hit  = sel && legal && wr_data[SEN_BIT] && pend_vld && (wr_gain == pend);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl       <= '0;
      pend      <= G_RST;
      pend_vld  <= 1'b0;
      gain_comm <= G_RST;
    end else begin
      if (sel) begin
        ctl.sen  <= wr_data[SEN_BIT];
        ctl.ben  <= wr_data[BEN_BIT];
        ctl.rate <= wr_data[RATE_BIT];
      end
      if (stage_hit) begin
        pend     <= wr_gain;
        pend_vld <= 1'b1;
      end
      if (commit_hit) begin
        gain_comm <= wr_gain;
        pend_vld  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/tsense_period_timer.sv
module tsense_period_timer
  import tsense_pkg::*;
#(
  parameter int SHORT_TICKS = 60,
  parameter int LONG_TICKS  = 600
) (
  input  logic    clk,
  input  logic    rst,
  input  period_e mode,
  input  logic    tick,
  output logic    hit,
  output logic    req
);

  localparam int MAX_TICKS = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
  localparam int CNT_W     = (MAX_TICKS > 2) ? $clog2(MAX_TICKS) : 1;
  localparam logic [CNT_W-1:0] LIM_S = CNT_W'(SHORT_TICKS - 1);
  localparam logic [CNT_W-1:0] LIM_L = CNT_W'(LONG_TICKS - 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  period_e          mode_q;
  logic             restart;

  assign lim     = (mode == PER_LONG) ? LIM_L : LIM_S;
  assign restart = (mode != mode_q) || (mode == PER_OFF);
  assign hit     = !restart && tick && (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      mode_q <= PER_OFF;
      req    <= 1'b0;
    end else begin
      mode_q <= mode;
      req    <= hit;
      if (restart)
        cnt <= '0;
      else if (tick)
        cnt <= (cnt == lim) ? '0 : cnt + 1'b1;
    end
  end

endmodule

// File: rtl/tsense_trim_regs.sv
module tsense_trim_regs #(
  parameter int ANA_W = 6,
  parameter int DIG_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic [ANA_W-1:0] ana_in,
  input  logic [DIG_W-1:0] dig_in,
  output logic [ANA_W-1:0] fin_ana,
  output logic [DIG_W-1:0] fin_dig,
  output logic             dig_neg
);

  always_ff @(posedge clk) begin
    if (rst) begin
      fin_ana <= '0;
      fin_dig <= '0;
      dig_neg <= 1'b0;
    end else if (ld) begin
      fin_ana <= ana_in;
      fin_dig <= dig_in;
      dig_neg <= &dig_in;
    end
  end

endmodule

// File: rtl/tsense_sched.sv
module tsense_sched
  import tsense_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int GAIN_W      = 4,
  parameter int GAIN_MIN    = 4,
  parameter int GAIN_MAX    = 12,
  parameter int GAIN_RESET  = 8,
  parameter int ANA_W       = 6,
  parameter int DIG_W       = 3,
  parameter int SHORT_TICKS = 60,
  parameter int LONG_TICKS  = 600
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic              on_battery,
  input  logic              tick_1hz,
  input  logic              trim_ld,
  input  logic [ANA_W-1:0]  trim_ana,
  input  logic [DIG_W-1:0]  trim_dig,
  output logic              sense_req,
  output logic [GAIN_W-1:0] gain_q,
  output logic              trim_dig_neg
);

  localparam logic [GAIN_W-1:0] G_RST  = GAIN_RESET[GAIN_W-1:0];
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_ANA  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_DIG  = ADDR_W'(2);

  ctl_t              ctl;
  logic [GAIN_W-1:0] gain_comm;
  period_e           cur_mode;
  logic              fire;
  logic [ANA_W-1:0]  fin_ana;
  logic [DIG_W-1:0]  fin_dig;
  logic [DATA_W-1:0] rd_next;

  tsense_ctl_regs #(
    .ADDR_W(ADDR_W), .GAIN_W(GAIN_W), .GAIN_MIN(GAIN_MIN),
    .GAIN_MAX(GAIN_MAX), .GAIN_RESET(GAIN_RESET)
  ) u_ctl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctl(ctl), .gain_comm(gain_comm)
  );

  assign cur_mode = pick_period(ctl, on_battery);

  tsense_period_timer #(
    .SHORT_TICKS(SHORT_TICKS), .LONG_TICKS(LONG_TICKS)
  ) u_timer (
    .clk(clk), .rst(rst), .mode(cur_mode), .tick(tick_1hz),
    .hit(fire), .req(sense_req)
  );

  tsense_trim_regs #(.ANA_W(ANA_W), .DIG_W(DIG_W)) u_trim (
    .clk(clk), .rst(rst), .ld(trim_ld), .ana_in(trim_ana), .dig_in(trim_dig),
    .fin_ana(fin_ana), .fin_dig(fin_dig), .dig_neg(trim_dig_neg)
  );

  // Gain hand-off to the correction math, sampled on the firing tick
  always_ff @(posedge clk) begin
    if (rst)       gain_q <= G_RST;
    else if (fire) gain_q <= gain_comm;
  end

  // Host read map
  always_comb begin
    rd_next = '0;
    if (rd_addr == A_CTL) begin
      rd_next[SEN_BIT]      = ctl.sen;
      rd_next[BEN_BIT]      = ctl.ben;
      rd_next[RATE_BIT]     = ctl.rate;
      rd_next[GAIN_W-1:0]   = gain_comm;
    end else if (rd_addr == A_ANA) begin
      rd_next[ANA_W-1:0]    = fin_ana;
    end else if (rd_addr == A_DIG) begin
      rd_next[DIG_W-1:0]    = fin_dig;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

endmodule

// File: rtl/tsense_sched_chk.sv
module tsense_sched_chk
  import tsense_pkg::*;
#(
  parameter int ADDR_W   = 2,
  parameter int GAIN_W   = 4,
  parameter int GAIN_MIN = 4,
  parameter int GAIN_MAX = 12,
  parameter int ANA_W    = 6,
  parameter int DIG_W    = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              sense_req,
  input period_e           cur_mode,
  input logic [GAIN_W-1:0] gain_q,
  input logic [GAIN_W-1:0] gain_comm,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              wr_sen,
  input logic              trim_ld,
  input logic [ANA_W-1:0]  fin_ana,
  input logic [DIG_W-1:0]  fin_dig,
  input logic              dig_neg
);

  localparam logic [GAIN_W-1:0] G_LO = GAIN_MIN[GAIN_W-1:0];
  localparam logic [GAIN_W-1:0] G_HI = GAIN_MAX[GAIN_W-1:0];

  p_single_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    sense_req |=> !sense_req);

  p_req_needs_mode_r4: assert property (@(posedge clk) disable iff (rst)
    sense_req |-> $past(cur_mode != PER_OFF));

  p_gain_window_r8: assert property (@(posedge clk) disable iff (rst)
    (gain_comm >= G_LO) && (gain_comm <= G_HI));

  p_commit_by_enable_write_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(gain_comm) |-> $past(wr_en && (wr_addr == '0) && wr_sen));

  p_gain_moves_with_req_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(gain_q) |-> sense_req);

  p_trim_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !trim_ld |=> ($stable(fin_ana) && $stable(fin_dig)));

  p_neg_flag_r11: assert property (@(posedge clk) disable iff (rst)
    dig_neg == (fin_dig == {DIG_W{1'b1}}));

endmodule

bind tsense_sched tsense_sched_chk #(
  .ADDR_W(ADDR_W), .GAIN_W(GAIN_W), .GAIN_MIN(GAIN_MIN),
  .GAIN_MAX(GAIN_MAX), .ANA_W(ANA_W), .DIG_W(DIG_W)
) u_chk (
  .clk(clk), .rst(rst), .sense_req(sense_req), .cur_mode(cur_mode),
  .gain_q(gain_q), .gain_comm(gain_comm), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_sen(wr_data[7]), .trim_ld(trim_ld), .fin_ana(fin_ana),
  .fin_dig(fin_dig), .dig_neg(trim_dig_neg)
);

// File: tb/tsense_sched_bench.sv
`timescale 1ns/1ps
module tsense_sched_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       on_battery = 1'b0;
  logic       tick_1hz = 1'b0;
  logic       trim_ld = 1'b0;
  logic [5:0] trim_ana = '0;
  logic [2:0] trim_dig = '0;
  logic       sense_req;
  logic [3:0] gain_q;
  logic       trim_dig_neg;

  always #2 clk = ~clk;

  tsense_sched u_tsense_sched (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .on_battery(on_battery),
    .tick_1hz(tick_1hz), .trim_ld(trim_ld), .trim_ana(trim_ana),
    .trim_dig(trim_dig), .sense_req(sense_req), .gain_q(gain_q),
    .trim_dig_neg(trim_dig_neg)
  );

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  int dbl    = 0;
  bit prev_req = 1'b0;
  bit started  = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit       m_sen, m_ben, m_rate, m_pv, m_req, m_neg;
  int       m_cnt, m_prev;
  int       m_comm, m_pend, m_gq;
  int       m_rd, m_ana, m_dig;

  always @(posedge clk) begin
    if (rst) begin
      m_sen = 0; m_ben = 0; m_rate = 0; m_pv = 0; m_req = 0; m_neg = 0;
      m_cnt = 0; m_prev = 0; m_comm = 8; m_pend = 8; m_gq = 8;
      m_rd = 0; m_ana = 0; m_dig = 0;
      started = 1'b1;
    end else begin
      int mode, lim, nrd, g;
      bit hit;
      if (!m_sen) mode = 0;
      else if (!on_battery) mode = 60;
      else if (!m_ben) mode = 0;
      else if (m_rate) mode = 60;
      else mode = 600;
      lim = (mode == 0) ? 60 : mode;
      hit = (mode != 0) && (mode == m_prev) && tick_1hz && (m_cnt == lim - 1);
      case (rd_addr)
        2'd0: nrd = (int'(m_sen) << 7) | (int'(m_ben) << 6) | (int'(m_rate) << 5) | m_comm;
        2'd1: nrd = m_ana;
        2'd2: nrd = m_dig;
        default: nrd = 0;
      endcase
      if (mode != m_prev || mode == 0) m_cnt = 0;
      else if (tick_1hz) m_cnt = (m_cnt == lim - 1) ? 0 : m_cnt + 1;
      m_prev = mode;
      if (hit) m_gq = m_comm;
      m_req = hit;
      m_rd  = nrd;
      if (trim_ld) begin
        m_ana = trim_ana; m_dig = trim_dig; m_neg = (trim_dig == 3'b111);
      end
      if (wr_en && wr_addr == 2'd0) begin
        g = wr_data[3:0];
        if (g >= 4 && g <= 12) begin
          if (!wr_data[7]) begin m_pend = g; m_pv = 1; end
          else if (m_pv && g == m_pend) begin m_comm = g; m_pv = 0; end
        end
        m_sen = wr_data[7]; m_ben = wr_data[6]; m_rate = wr_data[5];
      end
    end
  end

  // Per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (started && !rst) begin
      chk(sense_req == m_req, "R2 sense_req vs model", sense_req, m_req);
      chk(gain_q == m_gq[3:0], "R9 gain_q vs model", gain_q, m_gq);
      chk(rd_data == m_rd[7:0], "R10 rd_data vs model", rd_data, m_rd);
      chk(trim_dig_neg == m_neg, "R11 trim_dig_neg vs model", trim_dig_neg, m_neg);
      if (sense_req) begin
        pulses++;
        if (prev_req) dbl++;
      end
      prev_req = sense_req;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); rd_addr = a;
    @(negedge clk); v = rd_data;
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      @(negedge clk); tick_1hz = 1'b1;
      @(negedge clk); tick_1hz = 1'b0;
    end
  endtask

  task automatic expect_pulses(input int n_ticks, input int n_exp, input string tag);
    int p0;
    p0 = pulses;
    ticks(n_ticks);
    idle(3);
    chk(pulses - p0 == n_exp, tag, pulses - p0, n_exp);
  endtask

  task automatic load_trim(input logic [5:0] a, input logic [2:0] d);
    @(negedge clk); trim_ld = 1'b1; trim_ana = a; trim_dig = d;
    @(negedge clk); trim_ld = 1'b0;
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] v;
    idle(4);
    rst = 1'b0;
    idle(1);

    // R1: reset state
    chk(sense_req == 1'b0, "R1 sense_req after reset", sense_req, 0);
    chk(gain_q == 4'h8, "R1 gain_q after reset", gain_q, 8);
    rd(2'd0, v); chk(v == 8'h08, "R1 control readback", v, 8'h08);
    rd(2'd1, v); chk(v == 8'h00, "R1 analog trim reset", v, 0);
    rd(2'd2, v); chk(v == 8'h00, "R1 digital trim reset", v, 0);

    // R2: main supply, 60-tick interval
    wr(2'd0, 8'h88);
    expect_pulses(59, 0, "R2 no pulse before tick 60");
    expect_pulses(1, 1, "R2 pulse at tick 60");
    expect_pulses(60, 1, "R2 second interval");

    // R6: disable mid-count then re-enable restarts the count
    ticks(30);
    wr(2'd0, 8'h08);
    wr(2'd0, 8'h88);
    expect_pulses(59, 0, "R6 restart after disable, 59 ticks");
    expect_pulses(1, 1, "R6 restart after disable, tick 60");

    // R3: battery mode selection
    @(negedge clk); on_battery = 1'b1;
    expect_pulses(700, 0, "R3 battery flags 00 off");
    wr(2'd0, 8'hA8);
    expect_pulses(700, 0, "R3 battery flags 01 off");
    wr(2'd0, 8'hC8);
    expect_pulses(599, 0, "R3 battery 10 before tick 600");
    expect_pulses(1, 1, "R3 battery 10 at tick 600");
    wr(2'd0, 8'hE8);
    expect_pulses(59, 0, "R3 battery 11 before tick 60");
    expect_pulses(1, 1, "R3 battery 11 at tick 60");

    // R6: interval class change restarts
    ticks(30);
    wr(2'd0, 8'hC8);
    wr(2'd0, 8'hE8);
    expect_pulses(59, 0, "R6 restart after class change, 59 ticks");
    expect_pulses(1, 1, "R6 restart after class change, tick 60");

    // R4: sense disabled, battery flags set
    wr(2'd0, 8'h68);
    expect_pulses(200, 0, "R4 disabled on battery");
    @(negedge clk); on_battery = 1'b0;
    expect_pulses(200, 0, "R4 disabled on main");

    // R5: no pulse held longer than one clock so far
    chk(dbl == 0, "R5 single-cycle pulses", dbl, 0);

    // R7: two-step gain write
    wr(2'd0, 8'h0A);
    rd(2'd0, v); chk(v == 8'h08, "R7 staged code not yet committed", v, 8'h08);
    wr(2'd0, 8'h8A);
    rd(2'd0, v); chk(v == 8'h8A, "R7 commit with matching code", v, 8'h8A);
    chk(gain_q == 4'h8, "R9 gain_q waits for pulse", gain_q, 8);
    expect_pulses(60, 1, "R2 pulse after commit");
    chk(gain_q == 4'hA, "R9 gain_q takes committed code", gain_q, 4'hA);

    // R7: mismatching enable write does not commit; staged code kept
    wr(2'd0, 8'h05);
    wr(2'd0, 8'h86);
    rd(2'd0, v); chk(v == 8'h8A, "R7 mismatch ignored", v, 8'h8A);
    wr(2'd0, 8'h85);
    rd(2'd0, v); chk(v == 8'h85, "R7 staged code survives mismatch", v, 8'h85);

    // R8: out-of-window codes
    wr(2'd0, 8'h0D);
    wr(2'd0, 8'h8D);
    rd(2'd0, v); chk(v == 8'h85, "R8 code 1101 rejected", v, 8'h85);
    wr(2'd0, 8'h03);
    wr(2'd0, 8'h83);
    rd(2'd0, v); chk(v == 8'h85, "R8 code 0011 rejected", v, 8'h85);
    wr(2'd0, 8'h04);
    wr(2'd0, 8'h84);
    rd(2'd0, v); chk(v == 8'h84, "R8 code 0100 accepted", v, 8'h84);
    wr(2'd0, 8'h0C);
    wr(2'd0, 8'h8C);
    rd(2'd0, v); chk(v == 8'h8C, "R8 code 1100 accepted", v, 8'h8C);
    expect_pulses(60, 1, "R9 pulse with boundary code");
    chk(gain_q == 4'hC, "R9 gain_q boundary code", gain_q, 4'hC);

    // R10: trim results, read-only to host
    load_trim(6'h2A, 3'd5);
    wr(2'd1, 8'hFF);
    wr(2'd2, 8'hFF);
    wr(2'd3, 8'hFF);
    rd(2'd1, v); chk(v == 8'h2A, "R10 analog trim unaffected by write", v, 8'h2A);
    rd(2'd2, v); chk(v == 8'h05, "R10 digital trim unaffected by write", v, 8'h05);
    rd(2'd3, v); chk(v == 8'h00, "R10 address 3 reads zero", v, 0);
    rd(2'd0, v); chk(v == 8'h8C, "R10 control kept after trim writes", v, 8'h8C);
    chk(trim_dig_neg == 1'b0, "R11 code 101 not negative", trim_dig_neg, 0);

    // R11: negative code flag
    load_trim(6'h3F, 3'd7);
    idle(1);
    chk(trim_dig_neg == 1'b1, "R11 code 111 negative", trim_dig_neg, 1);
    load_trim(6'h00, 3'd6);
    idle(1);
    chk(trim_dig_neg == 1'b0, "R11 code 110 not negative", trim_dig_neg, 0);
    rd(2'd2, v); chk(v == 8'h06, "R10 digital trim reload", v, 8'h06);

    chk(dbl == 0, "R5 single-cycle pulses at end", dbl, 0);
    idle(2);
    summary();
    $finish;
  end

endmodule